// File: doc/BRIEF.md
# Hashed Page Table Chain Walker

This block turns a virtual page number into a physical frame number. It searches a hashed page table that lives in an external word-addressed memory. The page number is folded into a bucket index, and the bucket's head word gives the address of the first element of a collision chain. The walker then reads the elements one after another. At each element it compares the stored page number with the requested one. It stops when the tags match, when it reaches a null link, or when it has examined too many elements.

A client offers a request by raising `req_valid` with the page number while `busy` is low. The walker accepts only one lookup at a time. It reports the result as a one-cycle pulse on exactly one of `done`, `miss` or `err`, and `resp_pfn` carries the frame number on a hit. The memory port is a plain synchronous read: a one-cycle `mem_rd_en` pulse with an address, and the word appears on `mem_rd_data` in the next cycle, which is the timing of an inferred block RAM.

Memory layout: bucket heads sit at addresses 0 to 2^IDX_W-1. A head word uses only its low PTR_W bits as a pointer, and its upper bits are ignored. An element word is packed as {vpn, pfn, next}, with `next` in the low PTR_W bits, `pfn` above it and `vpn` at the top. A pointer of zero means the chain ends there.

Top module: `hpt_walker`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `miss`, `err` and `mem_rd_en` are all low.
- R2: The first memory read of a lookup goes to the bucket index. To form it, take the XOR of the upper and lower halves of the page number. Split that result into IDX_W-bit chunks starting at bit 0, padding the top chunk with zeros, and XOR the chunks together. The index is zero-extended to the address width.
- R3: If the low PTR_W bits of the head word are zero, the lookup ends with `miss` after exactly one memory read, whatever the upper bits of the head word hold.
- R4: Elements are examined in chain order. The element word is {vpn, pfn, next} with `next` in the low PTR_W bits. The first element whose vpn field equals the request ends the lookup with `done`, and `resp_pfn` holds that element's pfn field.
- R5: A non-matching element whose next field is zero ends the lookup with `miss`. On `miss` and `err`, `resp_pfn` is zero.
- R6: If MAX_STEPS elements have been examined, none matched and the last one has a non-zero next field, the lookup ends with `err`. A match or a null link on element MAX_STEPS still gives `done` or `miss`. No lookup makes more than MAX_STEPS+1 reads.
- R7: `busy` rises in the cycle after a request is accepted (`req_valid` high while `busy` is low). It stays high until the cycle of the response pulse, when it is low again. Requests raised while `busy` is high are ignored and do not change the result.
- R8: Each accepted lookup produces exactly one response pulse, one cycle long, on exactly one of `done`, `miss` or `err`.
- R9: Each memory read is a one-cycle `mem_rd_en` pulse issued only while `busy` is high. A lookup makes one head read plus one read for each element examined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request, taken when busy is low |
| req_vpn | input | VPN_W | Virtual page number to resolve |
| busy | output | 1 | A lookup is in progress |
| done | output | 1 | One-cycle pulse: the page was found |
| miss | output | 1 | One-cycle pulse: the chain ended without a match |
| err | output | 1 | One-cycle pulse: the step bound was reached |
| resp_pfn | output | PFN_W | Frame number on a hit, zero otherwise |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | PTR_W | Memory word address |
| mem_rd_data | input | VPN_W+PFN_W+PTR_W | Read data, valid the cycle after the strobe |

## Verification
The bench builds random chains and compares each lookup against a bench model of the walk. It also covers directed cases: an empty bucket whose head word has junk in its upper bits, a chain exactly MAX_STEPS long that ends in a hit, a miss or a back link, a self-loop, and duplicate tags. A design that tested the step bound before the null link would report `err` on a legal chain of full length. A design that read the whole head word as a pointer would walk a chain that does not exist, and one that kept searching after a match would return the later duplicate's frame. The bench drives a different request while the walker is busy and counts the read strobes. A walker that took the second request, skipped the head read or made extra reads shows up as a wrong result or a wrong read count.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_HEAD = 2'd2,
    ST_ELEM = 2'd3
  } walk_state_t;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W = 16,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn,
  output logic [IDX_W-1:0] idx
);
  localparam int HALF   = VPN_W / 2;
  localparam int NCHUNK = (HALF + IDX_W - 1) / IDX_W;
  localparam int PADW   = NCHUNK * IDX_W;

  logic [HALF-1:0] half_x;
  logic [PADW-1:0] padded;
  logic [IDX_W-1:0] acc [0:NCHUNK];

  assign half_x = vpn[2*HALF-1:HALF] ^ vpn[HALF-1:0];
  assign padded = PADW'(half_x);
  assign acc[0] = '0;

  for (genvar g = 0; g < NCHUNK; g++) begin : g_fold
    assign acc[g+1] = acc[g] ^ padded[g*IDX_W +: IDX_W];
  end

  assign idx = acc[NCHUNK];
endmodule

// File: rtl/hpt_elem_unpack.sv
module hpt_elem_unpack #(
  parameter int VPN_W = 16,
  parameter int PFN_W = 12,
  parameter int PTR_W = 8
) (
  input  logic [VPN_W+PFN_W+PTR_W-1:0] word,
  input  logic [VPN_W-1:0]             cmp_vpn,
  output logic [PFN_W-1:0]             elem_pfn,
  output logic [PTR_W-1:0]             elem_next,
  output logic                         tag_match,
  output logic                         next_null
);
  localparam int PFN_LO = PTR_W;
  localparam int VPN_LO = PTR_W + PFN_W;
  localparam int WORD_W = VPN_W + PFN_W + PTR_W;

  logic [VPN_W-1:0] elem_vpn;

  assign elem_vpn  = word[WORD_W-1:VPN_LO];
  assign elem_pfn  = word[VPN_LO-1:PFN_LO];
  assign elem_next = word[PTR_W-1:0];
  assign tag_match = (elem_vpn == cmp_vpn);
  assign next_null = (elem_next == '0);
endmodule

// File: rtl/hpt_step_ctr.sv
module hpt_step_ctr #(
  parameter int MAX_STEPS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic at_limit
);
  localparam int CW = $clog2(MAX_STEPS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign at_limit = (cnt == CW'(MAX_STEPS - 1));
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int VPN_W     = 16,
  parameter int PFN_W     = 12,
  parameter int IDX_W     = 4,
  parameter int PTR_W     = 8,
  parameter int MAX_STEPS = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         req_valid,
  input  logic [VPN_W-1:0]             req_vpn,
  output logic                         busy,
  output logic                         done,
  output logic                         miss,
  output logic                         err,
  output logic [PFN_W-1:0]             resp_pfn,
  output logic                         mem_rd_en,
  output logic [PTR_W-1:0]             mem_rd_addr,
  input  logic [VPN_W+PFN_W+PTR_W-1:0] mem_rd_data
);
  walk_state_t      st;
  logic             wait_head;
  logic [VPN_W-1:0] vpn_q;
  logic [IDX_W-1:0] hash_idx;
  logic [PFN_W-1:0] elem_pfn;
  logic [PTR_W-1:0] elem_next;
  logic             tag_match;
  logic             next_null;
  logic             at_limit;
  logic             accept;
  logic             elem_eval;

  assign accept    = (st == ST_IDLE) && req_valid;
  assign elem_eval = (st == ST_ELEM);

  hpt_hash #(
    .VPN_W(VPN_W),
    .IDX_W(IDX_W)
  ) u_hash (
    .vpn(req_vpn),
    .idx(hash_idx)
  );

  hpt_elem_unpack #(
    .VPN_W(VPN_W),
    .PFN_W(PFN_W),
    .PTR_W(PTR_W)
  ) u_unpack (
    .word     (mem_rd_data),
    .cmp_vpn  (vpn_q),
    .elem_pfn (elem_pfn),
    .elem_next(elem_next),
    .tag_match(tag_match),
    .next_null(next_null)
  );

  hpt_step_ctr #(
    .MAX_STEPS(MAX_STEPS)
  ) u_steps (
    .clk     (clk),
    .rst     (rst),
    .clear   (accept),
    .inc     (elem_eval),
    .at_limit(at_limit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_IDLE;
      wait_head   <= 1'b0;
      vpn_q       <= '0;
      busy        <= 1'b0;
      done        <= 1'b0;
      miss        <= 1'b0;
      err         <= 1'b0;
      resp_pfn    <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      done      <= 1'b0;
      miss      <= 1'b0;
      err       <= 1'b0;
      mem_rd_en <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            vpn_q       <= req_vpn;
            mem_rd_addr <= PTR_W'(hash_idx);
            mem_rd_en   <= 1'b1;
            wait_head   <= 1'b1;
            busy        <= 1'b1;
            st          <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          st <= wait_head ? ST_HEAD : ST_ELEM;
        end
        ST_HEAD: begin
          if (next_null) begin
            miss     <= 1'b1;
            resp_pfn <= '0;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            mem_rd_addr <= elem_next;
            mem_rd_en   <= 1'b1;
            wait_head   <= 1'b0;
            st          <= ST_WAIT;
          end
        end
        ST_ELEM: begin
          if (tag_match) begin
            done     <= 1'b1;
            resp_pfn <= elem_pfn;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end else if (next_null) begin
            miss     <= 1'b1;
            resp_pfn <= '0;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end else if (at_limit) begin
            err      <= 1'b1;
            resp_pfn <= '0;
            busy     <= 1'b0;
            st       <= ST_IDLE;
          end else begin
            mem_rd_addr <= elem_next;
            mem_rd_en   <= 1'b1;
            st          <= ST_WAIT;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int PFN_W     = 12,
  parameter int MAX_STEPS = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             busy,
  input logic             done,
  input logic             miss,
  input logic             err,
  input logic [PFN_W-1:0] resp_pfn,
  input logic             mem_rd_en
);
  localparam int CW = $clog2(MAX_STEPS + 2) + 1;

  logic [CW-1:0] rd_cnt;
  logic          any_resp;

  assign any_resp = done || miss || err;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt <= '0;
    end else if (req_valid && !busy) begin
      rd_cnt <= '0;
    end else if (mem_rd_en) begin
      rd_cnt <= rd_cnt + 1'b1;
    end
  end

  assert_accept_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  assert_resp_clears_busy_R7: assert property (@(posedge clk) disable iff (rst)
    any_resp |-> !busy);

  assert_busy_fall_resp_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> any_resp);

  assert_one_outcome_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, miss, err}));

  assert_resp_after_busy_R8: assert property (@(posedge clk) disable iff (rst)
    any_resp |-> $past(busy));

  assert_rd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  assert_rd_in_lookup_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> busy);

  assert_step_bound_R6: assert property (@(posedge clk) disable iff (rst)
    rd_cnt <= CW'(MAX_STEPS + 1));

  assert_pfn_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (miss || err) |-> (resp_pfn == '0));
endmodule

bind hpt_walker hpt_walker_chk #(
  .PFN_W    (PFN_W),
  .MAX_STEPS(MAX_STEPS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .busy     (busy),
  .done     (done),
  .miss     (miss),
  .err      (err),
  .resp_pfn (resp_pfn),
  .mem_rd_en(mem_rd_en)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  localparam int VPN_W     = 16;
  localparam int PFN_W     = 12;
  localparam int IDX_W     = 4;
  localparam int PTR_W     = 8;
  localparam int MAX_STEPS = 16;
  localparam int W         = VPN_W + PFN_W + PTR_W;
  localparam int DEPTH     = 1 << PTR_W;
  localparam int NB        = 1 << IDX_W;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_valid = 1'b0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic             busy, done, miss, err, mem_rd_en;
  logic [PFN_W-1:0] resp_pfn;
  logic [PTR_W-1:0] mem_rd_addr;
  logic [W-1:0]     mem_rd_data = '0;

  logic [W-1:0]     mem [0:DEPTH-1];
  logic [PTR_W-1:0] head_ptr [0:NB-1];
  logic [VPN_W-1:0] stored [0:63];

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int rd_total = 0;
  int resp_total = 0;
  logic want_first = 1'b0;
  logic [PTR_W-1:0] first_addr = '0;

  always #4 clk = ~clk;

  hpt_walker #(
    .VPN_W(VPN_W), .PFN_W(PFN_W), .IDX_W(IDX_W),
    .PTR_W(PTR_W), .MAX_STEPS(MAX_STEPS)
  ) u_hpt_walker (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_vpn(req_vpn),
    .busy(busy), .done(done), .miss(miss), .err(err), .resp_pfn(resp_pfn),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (mem_rd_en) rd_total <= rd_total + 1;
    if (done || miss || err) resp_total <= resp_total + 1;
    if (req_valid && !busy && !rst) want_first <= 1'b1;
    else if (mem_rd_en && want_first) begin
      first_addr <= mem_rd_addr;
      want_first <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [IDX_W-1:0] ref_hash(input logic [VPN_W-1:0] v);
    logic [VPN_W/2-1:0] hx;
    logic [IDX_W-1:0] acc;
    hx = v[VPN_W-1:VPN_W/2] ^ v[VPN_W/2-1:0];
    acc = '0;
    for (int i = 0; i < VPN_W/2; i++) acc[i % IDX_W] ^= hx[i];
    return acc;
  endfunction

  function automatic logic [W-1:0] mk_elem(input logic [VPN_W-1:0] v,
                                           input logic [PFN_W-1:0] f,
                                           input logic [PTR_W-1:0] nx);
    return {v, f, nx};
  endfunction

  task automatic set_head(input int b, input logic [PTR_W-1:0] p);
    logic [W-PTR_W-1:0] junk;
    junk = (W-PTR_W)'({$urandom, $urandom});
    head_ptr[b] = p;
    mem[b] = {junk, p};
  endtask

  task automatic clear_mem();
    for (int a = 0; a < DEPTH; a++) mem[a] = '0;
    for (int b = 0; b < NB; b++) set_head(b, '0);
  endtask

  task automatic ref_walk(input logic [VPN_W-1:0] v, output int kind,
                          output logic [PFN_W-1:0] f, output int nreads);
    logic [PTR_W-1:0] p;
    logic [W-1:0] e;
    int n;
    p = mem[ref_hash(v)][PTR_W-1:0];
    n = 0; kind = 1; f = '0;
    if (p != '0) begin
      for (int s = 0; s < 1000; s++) begin
        e = mem[p];
        n++;
        if (e[W-1:W-VPN_W] == v) begin kind = 0; f = e[PTR_W+PFN_W-1:PTR_W]; break; end
        if (e[PTR_W-1:0] == '0) begin kind = 1; break; end
        if (n == MAX_STEPS) begin kind = 2; break; end
        p = e[PTR_W-1:0];
      end
    end
    nreads = 1 + n;
  endtask

  task automatic lookup(input logic [VPN_W-1:0] v);
    int kind, nreads, rd0, rs0, act, cyc;
    logic [PFN_W-1:0] f;
    string tag;
    ref_walk(v, kind, f, nreads);
    tag = (kind == 0) ? "R4" : (kind == 2) ? "R6" : (nreads == 1) ? "R3" : "R5";
    @(negedge clk);
    cyc = 0;
    while (busy && cyc < 200) begin @(negedge clk); cyc++; end
    rd0 = rd_total;
    rs0 = resp_total;
    req_valid = 1'b1; req_vpn = v;
    @(negedge clk);
    check(busy == 1'b1, "R7 busy after accept", int'(busy), 1);
    req_vpn = ~v ^ VPN_W'(16'h5a5a);
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || miss || err) && cyc < 200) begin @(negedge clk); cyc++; end
    act = done ? 0 : miss ? 1 : err ? 2 : 3;
    check(act == kind, tag, act, kind);
    check(resp_pfn == f, tag, int'(resp_pfn), int'(f));
    check(busy == 1'b0, "R7 busy low at response", int'(busy), 0);
    check(first_addr == PTR_W'(ref_hash(v)), "R2 head address", int'(first_addr),
          int'(ref_hash(v)));
    check(rd_total - rd0 == nreads, "R9 read count", rd_total - rd0, nreads);
    @(negedge clk);
    @(negedge clk);
    check(resp_total - rs0 == 1, "R8 single response", resp_total - rs0, 1);
    check(!(done || miss || err) && !busy, "R8 idle after response",
          int'({done, miss, err, busy}), 0);
  endtask

  initial begin
    while (cycles < 150000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=%0d expected=0", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [VPN_W-1:0] x;
    int b, nst;
    void'($urandom(32'd20240611));
    clear_mem();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    check({busy, done, miss, err, mem_rd_en} == 5'b0, "R1 reset outputs",
          int'({busy, done, miss, err, mem_rd_en}), 0);
    rst = 1'b0;
    @(negedge clk);
    check({busy, done, miss, err, mem_rd_en} == 5'b0, "R1 after reset",
          int'({busy, done, miss, err, mem_rd_en}), 0);

    // R3: every bucket empty, heads carry junk upper bits
    lookup(16'h1234);
    lookup(16'hffff);

    // R6: chain exactly MAX_STEPS long
    x = 16'hbeef;
    b = int'(ref_hash(x));
    for (int i = 0; i < MAX_STEPS; i++)
      mem[32+i] = mk_elem(x ^ VPN_W'(i + 1), PFN_W'(i + 100),
                          (i == MAX_STEPS-1) ? '0 : PTR_W'(33 + i));
    set_head(b, 8'd32);
    mem[32+MAX_STEPS-1] = mk_elem(x, 12'h3c5, '0);
    lookup(x);
    mem[32+MAX_STEPS-1] = mk_elem(x ^ 16'h8000, 12'h3c5, '0);
    lookup(x);
    mem[32+MAX_STEPS-1] = mk_elem(x ^ 16'h8000, 12'h3c5, 8'd32);
    lookup(x);

    // R6: self loop, R4: duplicate tags resolve in chain order
    clear_mem();
    x = 16'h0f0f;
    mem[80] = mk_elem(16'h7777, 12'h011, 8'd80);
    set_head(int'(ref_hash(x)), 8'd80);
    lookup(x);
    x = 16'h4242;
    mem[90] = mk_elem(16'h9999, 12'h001, 8'd91);
    mem[91] = mk_elem(x, 12'h0aa, 8'd92);
    mem[92] = mk_elem(x, 12'h0bb, '0);
    set_head(int'(ref_hash(x)), 8'd90);
    lookup(x);

    // random tables
    for (int round = 0; round < 3; round++) begin
      clear_mem();
      nst = 48;
      for (int i = 0; i < nst; i++) begin
        x = VPN_W'($urandom);
        stored[i] = x;
        b = int'(ref_hash(x));
        mem[16+i] = mk_elem(x, PFN_W'($urandom), head_ptr[b]);
        set_head(b, PTR_W'(16 + i));
      end
      for (int k = 0; k < 50; k++) begin
        if (($urandom % 10) < 7) lookup(stored[$urandom % nst]);
        else lookup(VPN_W'($urandom));
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule